// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Sense Unit

This block watches a bank of general-purpose input pins and turns configured pin conditions into sticky interrupt status bits. Each pin has a two-bit condition code that selects low level, high level, rising edge or falling edge. A per-pin any-edge bit takes priority over that code. Edges are found by comparing the sampled level in the current cycle with a stored copy of the previous cycle's level. Only pins whose direction bit marks them as inputs are evaluated.

Configuration is written through a small write port: a select code, a data word and an enable. That port loads the direction, condition, any-edge and mask registers, and it also carries the write-one-to-clear command for the status vector. Every pin is evaluated again in every cycle. So a level condition that still holds sets its status bit again on the cycle after a clear or a reconfiguration. A parameter picks one of two request layouts: a single request line that covers all pins, or two lines, one for each half of the bank. The pins are assumed to be synchronous to `clk` already.

Top module: `gpio_irq_sense`

## Requirements
- R1: While `rst_n` is low, `status` and `irq_req` are zero on the next clock edge. The direction, condition, any-edge, mask and previous-level registers all reset to zero. After release, with every pin low and all codes 00, every status bit sets on the first edge.
- R2: Condition code 00 sets the pin's status bit on every edge at which the pin is low. Code 01 does the same while the pin is high. The bit is visible after that edge.
- R3: Code 10 sets status on an edge where the stored previous level is 0 and the pin is 1. Code 11 sets status on an edge where the previous level is 1 and the pin is 0. A level that is simply held produces nothing.
- R4: The code for pin p sits at bits [2(p mod 16)+1 : 2(p mod 16)]. Pins 0–15 use the low-half word, written with `wr_sel`=1. Pins 16–31 use the high-half word, written with `wr_sel`=2.
- R5: When a pin's any-edge bit is 1 (`wr_sel`=3), every change of level sets status and the condition code is ignored. A steady high level on such a pin sets nothing.
- R6: Status bits are sticky. A write with `wr_sel`=5 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R7: If a clear and a detection hit the same status bit at the same edge, the bit ends up set.
- R8: A pin whose direction bit is 1 (`wr_sel`=0, 1 means output) never sets status.
- R9: With `SPLIT_IRQ`=1, `irq_req[0]` is the OR of status AND mask over pins 0–15, and `irq_req[1]` is the same over pins 16–31. The mask is written with `wr_sel`=4.
- R10: With `SPLIT_IRQ`=0, `irq_req[0]` is the OR of status AND mask over all pins, and `irq_req[1]` is 0. Select codes 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NPINS | Synchronized pin levels |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 3 | Target: 0 direction, 1 codes low half, 2 codes high half, 3 any-edge, 4 mask, 5 status clear |
| wr_data | input | NPINS | Write data, or the clear mask when `wr_sel`=5 |
| status | output | NPINS | Sticky interrupt status |
| irq_req | output | 2 | Masked interrupt request lines |

## Verification
The bench builds two copies with the default 32 pins and drives both from the same inputs: one with `SPLIT_IRQ`=1 and one with `SPLIT_IRQ`=0. This lets a single stimulus sequence compare the per-half request lines against the combined line. The tests use pins on both sides of the half boundary (pin 20 sits in the high-half code word), so an error in the code-field position or in the split of the request lines shows up as a wrong status bit or a wrong request line.

// File: rtl/gpio_sense_pkg.sv
// Shared definitions for the GPIO interrupt sense unit.
// Assumes nothing beyond a 3-bit write select on the configuration port.
package gpio_sense_pkg;
    typedef enum logic [2:0] {
        SEL_DIR    = 3'd0,
        SEL_CODELO = 3'd1,
        SEL_CODEHI = 3'd2,
        SEL_ANY    = 3'd3,
        SEL_MASK   = 3'd4,
        SEL_CLR    = 3'd5
    } sense_sel_e;

    localparam logic [1:0] CODE_LOW  = 2'b00;
    localparam logic [1:0] CODE_HIGH = 2'b01;
    localparam logic [1:0] CODE_RISE = 2'b10;
    localparam logic [1:0] CODE_FALL = 2'b11;
endpackage

// File: rtl/gpio_sense_cfg.sv
// Configuration registers: direction, condition codes, any-edge and mask.
// Decodes the write port and presents the status clear vector for one cycle.
// Assumes: NPINS is even; each code half holds NPINS/2 two-bit fields.
module gpio_sense_cfg
    import gpio_sense_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [NPINS-1:0]   wr_data,
    output logic [NPINS-1:0]   dir_q,
    output logic [2*NPINS-1:0] code_q,
    output logic [NPINS-1:0]   any_q,
    output logic [NPINS-1:0]   mask_q,
    output logic [NPINS-1:0]   clr_vec
);
    // Load the addressed register on a write; everything clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            code_q <= '0;
            any_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_DIR:    dir_q               <= wr_data;
                SEL_CODELO: code_q[NPINS-1:0]   <= wr_data;
                SEL_CODEHI: code_q[2*NPINS-1:NPINS] <= wr_data;
                SEL_ANY:    any_q               <= wr_data;
                SEL_MASK:   mask_q              <= wr_data;
                default:    ;
            endcase
        end
    end

    // Clear vector is only live during a status-clear write.
    always_comb clr_vec = (wr_en && wr_sel == SEL_CLR) ? wr_data : '0;
endmodule

// File: rtl/gpio_sense_pin.sv
// Condition detector for one pin.
// Assumes pin_now is already synchronous and prev is last cycle's level.
module gpio_sense_pin
    import gpio_sense_pkg::*;
(
    input  logic       pin_now,
    input  logic       prev,
    input  logic       is_output,
    input  logic       any_edge,
    input  logic [1:0] code,
    output logic       hit
);
    // Pick the active condition; any-edge takes priority over the code.
    always_comb begin
        if (is_output) begin
            hit = 1'b0;
        end else if (any_edge) begin
            hit = pin_now ^ prev;
        end else begin
            case (code)
                CODE_LOW:  hit = ~pin_now;
                CODE_HIGH: hit = pin_now;
                CODE_RISE: hit = pin_now & ~prev;
                default:   hit = ~pin_now & prev;
            endcase
        end
    end
endmodule

// File: rtl/gpio_sense_irq.sv
// Folds masked status into one combined or two per-half request lines.
// Assumes NPINS is even when SPLIT_IRQ is set.
module gpio_sense_irq #(
    parameter int NPINS     = 32,
    parameter bit SPLIT_IRQ = 1'b0
) (
    input  logic [NPINS-1:0] status,
    input  logic [NPINS-1:0] mask,
    output logic [1:0]       irq_req
);
    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] pend;
    // Only unmasked status can raise a request.
    always_comb pend = status & mask;

    generate
        if (SPLIT_IRQ) begin : g_split
            // One line per half of the bank.
            always_comb irq_req = {|pend[NPINS-1:HALF], |pend[HALF-1:0]};
        end else begin : g_single
            // A single line for the whole bank.
            always_comb irq_req = {1'b0, |pend};
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_sense.sv
// Top: per-pin interrupt sense with sticky write-one-to-clear status.
// Every pin is evaluated every cycle, so level conditions re-assert after
// any clear or reconfiguration. Assumes pin_in is synchronous to clk.
module gpio_irq_sense #(
    parameter int NPINS     = 32,
    parameter bit SPLIT_IRQ = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] status,
    output logic [1:0]       irq_req
);
    logic [NPINS-1:0]   dir_q;
    logic [2*NPINS-1:0] code_q;
    logic [NPINS-1:0]   any_q;
    logic [NPINS-1:0]   mask_q;
    logic [NPINS-1:0]   clr_vec;
    logic [NPINS-1:0]   prev_q;
    logic [NPINS-1:0]   hit;

    gpio_sense_cfg #(.NPINS(NPINS)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .dir_q   (dir_q),
        .code_q  (code_q),
        .any_q   (any_q),
        .mask_q  (mask_q),
        .clr_vec (clr_vec)
    );

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            gpio_sense_pin i_pin (
                .pin_now   (pin_in[p]),
                .prev      (prev_q[p]),
                .is_output (dir_q[p]),
                .any_edge  (any_q[p]),
                .code      (code_q[2*p +: 2]),
                .hit       (hit[p])
            );
        end
    endgenerate

    // Keep last cycle's pin levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_in;
    end

    // Sticky status: clear first, then detection sets on top (detection wins).
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | hit;
    end

    gpio_sense_irq #(.NPINS(NPINS), .SPLIT_IRQ(SPLIT_IRQ)) i_irq (
        .status  (status),
        .mask    (mask_q),
        .irq_req (irq_req)
    );
endmodule

// File: rtl/gpio_irq_sense_chk.sv
// Checker for gpio_irq_sense, attached through bind.
// Observes ports plus the direction and mask registers.
module gpio_irq_sense_chk #(
    parameter int NPINS     = 32,
    parameter bit SPLIT_IRQ = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic [NPINS-1:0] wr_data,
    input logic [NPINS-1:0] status,
    input logic [1:0]       irq_req,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] mask_q
);
    logic [NPINS-1:0] clr_seen;
    // Clear command as seen at the ports.
    always_comb clr_seen = (wr_en && wr_sel == 3'd5) ? wr_data : '0;

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (status == '0)); // R1

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(clr_seen)) & ~status) == '0)); // R6

    AST_OUTPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & $past(dir_q)) == '0)); // R8

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != 2'b00) |-> ((status & mask_q) != '0)); // R9

    AST_PEND_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask_q) != '0) |-> (irq_req != 2'b00)); // R10

    AST_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !SPLIT_IRQ |-> !irq_req[1]); // R10
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NPINS(NPINS), .SPLIT_IRQ(SPLIT_IRQ)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .status  (status),
    .irq_req (irq_req),
    .dir_q   (dir_q),
    .mask_q  (mask_q)
);

// File: tb/test_gpio_irq_sense.sv
module test_gpio_irq_sense;
    localparam int N = 32;
    localparam logic [31:0] BASE = 32'h5555_5555; // all codes 01 (high level)

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_sel = '0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] status, status_one;
    logic [1:0]   irq_req, irq_one;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    gpio_irq_sense #(.NPINS(N), .SPLIT_IRQ(1'b1)) i_gpio_irq_sense (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .status(status), .irq_req(irq_req));

    gpio_irq_sense #(.NPINS(N), .SPLIT_IRQ(1'b0)) i_gpio_irq_sense_one (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .status(status_one), .irq_req(irq_one));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pin_in[p] = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        idle(3);
        check("R1 status in reset", status, 32'h0);
        check("R1 irq in reset", {30'b0, irq_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 R2 low level after release", status, 32'hFFFF_FFFF);
        wr(3'd1, BASE);
        wr(3'd2, BASE);
        wr(3'd5, 32'hFFFF_FFFF);
        check("R6 clear all", status, 32'h0);
    endtask

    task automatic t_level;
        set_pin(3, 1'b1);
        check("R2 high level", status, 32'h8);
        wr(3'd5, 32'h8);
        check("R7 clear loses to held level", status, 32'h8);
        pin_in[3] = 1'b0;
        wr(3'd5, 32'h8);
        check("R6 clear after level gone", status, 32'h0);
    endtask

    task automatic t_edges;
        logic [31:0] lo, hi;
        lo = (BASE & ~(32'h3 << 10)) | (32'h2 << 10); // pin 5 rising
        hi = (BASE & ~(32'h3 << 8)) | (32'h3 << 8);   // pin 20 falling (R4)
        wr(3'd1, lo);
        wr(3'd2, hi);
        idle(1);
        check("R3 quiet before edges", status, 32'h0);
        set_pin(5, 1'b1);
        check("R3 rising pin5", status, 32'h20);
        set_pin(5, 1'b0);
        check("R6 sticky after fall", status, 32'h20);
        wr(3'd5, 32'h0);
        check("R6 zero write no effect", status, 32'h20);
        wr(3'd5, 32'h20);
        check("R6 clear pin5", status, 32'h0);
        set_pin(20, 1'b1);
        check("R3 R4 rise ignored for falling code", status, 32'h0);
        set_pin(20, 1'b0);
        check("R3 R4 falling pin20", status, 32'h0010_0000);
        wr(3'd5, 32'h0010_0000);
        wr(3'd2, BASE);
        wr(3'd1, BASE);
        check("R6 edges cleared", status, 32'h0);
    endtask

    task automatic t_anyedge;
        wr(3'd3, 32'h80);
        set_pin(7, 1'b1);
        check("R5 any-edge rise", status, 32'h80);
        wr(3'd5, 32'h80);
        idle(1);
        check("R5 held high no re-assert", status, 32'h0);
        set_pin(7, 1'b0);
        check("R5 any-edge fall", status, 32'h80);
        wr(3'd3, 32'h0);
        wr(3'd5, 32'h80);
        check("R5 cleared", status, 32'h0);
    endtask

    task automatic t_dir;
        logic [31:0] lo;
        lo = BASE & ~(32'h3 << 18); // pin 9 low level
        wr(3'd0, 32'h200);
        wr(3'd1, lo);
        idle(2);
        check("R8 output pin silent", status, 32'h0);
        wr(3'd0, 32'h0);
        idle(1);
        check("R8 input pin low level", status, 32'h200);
        wr(3'd1, BASE);
        wr(3'd5, 32'h200);
        check("R8 cleared", status, 32'h0);
    endtask

    task automatic t_irq;
        wr(3'd4, 32'h0010_0008);
        set_pin(3, 1'b1);
        check("R9 low half line", {30'b0, irq_req}, 32'h1);
        check("R10 single line", {30'b0, irq_one}, 32'h1);
        wr(3'd2, (BASE & ~(32'h3 << 8)) | (32'h3 << 8));
        set_pin(20, 1'b1);
        set_pin(20, 1'b0);
        check("R9 both halves", {30'b0, irq_req}, 32'h3);
        pin_in[3] = 1'b0;
        wr(3'd5, 32'h8);
        check("R9 high half only", {30'b0, irq_req}, 32'h2);
        check("R10 single covers high half", {30'b0, irq_one}, 32'h1);
        wr(3'd4, 32'h1);
        check("R9 masked off", {30'b0, irq_req}, 32'h0);
        wr(3'd6, 32'hFFFF_FFFF);
        check("R10 unused select ignored", status, 32'h0010_0000);
        check("R10 twin status agrees", status_one, status);
    endtask

    initial begin
        t_reset();
        t_level();
        t_edges();
        t_anyedge();
        t_dir();
        t_irq();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule